// File: doc/BRIEF.md
# I2C GPIO Expander Register Core

This block is the register and pin core of an eight-pin I/O expander that sits behind a byte-level I2C target. A bit-level front end, which is not part of this block, decodes the bus. It hands the core start and stop events, each received write byte with a one-cycle valid strobe, and a one-cycle request whenever the controller wants a byte read back. The core keeps four 8-bit registers: the sampled pin levels, the output latch, a read-inversion mask and a direction mask. It returns the byte at the current register pointer on each read request.

Each pin behaves like an open-drain line with a pull-up. When its output latch bit and its direction bit are both 0, the core pulls the pin low. Otherwise the pin is released and follows an external level, which passes through a two-flop synchronizer first. The resolved levels are visible on `pin_level`. Whenever a pin's level actually changes, `pin_chg` pulses for one cycle on that pin, and `pin_level` shows the new value in the same cycle.

Top module: `gpx_regcore`

## Requirements
- R1: After reset `pin_level` is 0xFF, `pin_chg` is 0, the pointer is 0, the output latch is 0xFF, the inversion mask is 0x00 and the direction mask is 0xFF. A read issued before any pointer byte therefore returns 0xFF.
- R2: Bits [1:0] of the pointer select the register: 0 is the level register, 1 the output latch, 2 the inversion mask and 3 the direction mask. Pointer bits [7:2] are kept but select nothing.
- R3: The first byte after a start or stop event is taken as the pointer. Every later byte before the next event is written to the register that pointer selects. The pointer does not advance between bytes.
- R4: A start or a stop event makes the next byte a pointer byte again. If a byte strobe arrives in the same cycle as an event, that byte is dropped.
- R5: When `rd_req` is high at a clock edge, `rd_data` holds the selected register from that edge on. For register 0 the value is the pin levels XOR the inversion mask. Registers 1 to 3 read back as stored.
- R6: A write aimed at register 0 changes nothing: `pin_level` and the readback stay as they were.
- R7: A pin is pulled low when its direction bit OR its output bit is 0. Otherwise it takes the synchronized external level. `pin_level` shows the effect of a register write one clock after the edge that stores the byte.
- R8: A change on `pin_ext` reaches `pin_level` on the third rising edge after it is applied. A pin that is pulled low ignores its external level.
- R9: `pin_chg[i]` is high for exactly one cycle, in the cycle in which `pin_level[i]` takes a value different from its previous one, and at no other time.
- R10: A write to the inversion mask changes only the value read from register 0. It never changes `pin_level` and never raises `pin_chg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start or repeated-start event strobe |
| bus_stop | input | 1 | Stop event strobe |
| wr_valid | input | 1 | Received write byte strobe |
| wr_byte | input | 8 | Received write byte |
| rd_req | input | 1 | Read byte request strobe |
| rd_data | output | 8 | Byte returned for the last read request |
| pin_ext | input | 8 | External pin levels, asynchronous |
| pin_level | output | 8 | Resolved pin levels |
| pin_chg | output | 8 | Per-pin one-cycle change strobe |

## Verification
A corrupted pointer or a stuck byte counter shows up on the next write: the data byte lands in the wrong register, or it is taken as a new pointer. This is visible one clock later on `pin_level`, or on `rd_data` at the next read. A wrong latch or mask bit shows on `pin_level` one edge after the write. A wrong inversion shows only on a read of register 0. A fault in the synchronizer depth or in the change detection moves or drops the `pin_chg` pulse, and the bench checks that pulse cycle by cycle around each cause.

// File: rtl/gpx_regcore.sv
module gpx_regcore #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_start,
  input  logic            bus_stop,
  input  logic            wr_valid,
  input  logic [7:0]      wr_byte,
  input  logic            rd_req,
  output logic [7:0]      rd_data,
  input  logic [NPIN-1:0] pin_ext,
  output logic [NPIN-1:0] pin_level,
  output logic [NPIN-1:0] pin_chg
);

  localparam logic [1:0] SEL_LVL = 2'd0;
  localparam logic [1:0] SEL_OUT = 2'd1;
  localparam logic [1:0] SEL_POL = 2'd2;
  localparam logic [1:0] SEL_CFG = 2'd3;

  logic [7:0]      ptr_q;
  logic            have_ptr_q;
  logic [NPIN-1:0] out_q, pol_q, cfg_q, lvl_q;
  logic [NPIN-1:0] ext_m, ext_s;
  logic [NPIN-1:0] lvl_d;

  wire bus_evt = bus_start | bus_stop;
  wire wr_reg  = wr_valid & have_ptr_q & ~bus_evt;

  assign lvl_d = (cfg_q | out_q) & ext_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_m <= '1;
      ext_s <= '1;
    end else begin
      ext_m <= pin_ext;
      ext_s <= ext_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      have_ptr_q <= 1'b0;
    end else if (bus_evt) begin
      have_ptr_q <= 1'b0;
    end else if (wr_valid && !have_ptr_q) begin
      ptr_q      <= wr_byte;
      have_ptr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (wr_reg) begin
      case (ptr_q[1:0])
        SEL_OUT: out_q <= wr_byte[NPIN-1:0];
        SEL_POL: pol_q <= wr_byte[NPIN-1:0];
        SEL_CFG: cfg_q <= wr_byte[NPIN-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '1;
      pin_chg <= '0;
    end else begin
      lvl_q   <= lvl_d;
      pin_chg <= lvl_d ^ lvl_q;
    end
  end

  logic [NPIN-1:0] rd_sel;
  always_comb begin
    case (ptr_q[1:0])
      SEL_LVL: rd_sel = lvl_q ^ pol_q;
      SEL_OUT: rd_sel = out_q;
      SEL_POL: rd_sel = pol_q;
      default: rd_sel = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_req) rd_data <= 8'(rd_sel);
  end

  assign pin_level = lvl_q;

endmodule

// File: rtl/gpx_regcore_chk.sv
module gpx_regcore_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_start,
  input logic            bus_stop,
  input logic            wr_valid,
  input logic            rd_req,
  input logic [7:0]      rd_data,
  input logic [NPIN-1:0] pin_level,
  input logic [NPIN-1:0] pin_chg,
  input logic [7:0]      ptr_q,
  input logic            have_ptr_q,
  input logic [NPIN-1:0] out_q,
  input logic [NPIN-1:0] pol_q,
  input logic [NPIN-1:0] cfg_q
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_level == '1 && pin_chg == '0 && ptr_q == 8'h00 &&
                      out_q == '1 && pol_q == '0 && cfg_q == '1));

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_ptr_q && !bus_start && !bus_stop) |=> $stable(ptr_q));

  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> !have_ptr_q);

  p_lvl_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ptr_q[1:0] == 2'd0) |=> (rd_data[NPIN-1:0] == $past(pin_level ^ pol_q)));

  p_pull_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & ~$past(cfg_q | out_q)) == '0);

  p_chg_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg == (pin_level ^ $past(pin_level)));

endmodule

bind gpx_regcore gpx_regcore_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .wr_valid(wr_valid), .rd_req(rd_req), .rd_data(rd_data),
  .pin_level(pin_level), .pin_chg(pin_chg), .ptr_q(ptr_q),
  .have_ptr_q(have_ptr_q), .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
);

// File: tb/gpx_regcore_tb.sv
module gpx_regcore_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_data, pin_ext = 8'hFF, pin_level, pin_chg;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_regcore dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req), .rd_data(rd_data),
    .pin_ext(pin_ext), .pin_level(pin_level), .pin_chg(pin_chg)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic start_evt();
    bus_start = 1'b1; cyc(); bus_start = 1'b0;
  endtask

  task automatic stop_evt();
    bus_stop = 1'b1; cyc(); bus_stop = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    wr_valid = 1'b1; wr_byte = b; cyc(); wr_valid = 1'b0;
  endtask

  task automatic read_cur(string tag, logic [7:0] exp);
    rd_req = 1'b1; cyc(); rd_req = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic read_reg(string tag, logic [7:0] p, logic [7:0] exp);
    start_evt(); send(p); start_evt(); read_cur(tag, exp); stop_evt();
  endtask

  task automatic t_reset();
    check("R1 level", pin_level, 8'hFF);
    check("R1 chg", pin_chg, 8'h00);
    read_cur("R1 read at pointer 0", 8'hFF);
    read_reg("R1 R2 output reset", 8'h01, 8'hFF);
    read_reg("R1 R2 polarity reset", 8'h02, 8'h00);
    read_reg("R1 R2 config reset", 8'h03, 8'hFF);
  endtask

  task automatic t_drive_low();
    start_evt(); send(8'h03); send(8'h0F); stop_evt();
    check("R7 released outputs high", pin_level, 8'hFF);
    start_evt(); send(8'h01); send(8'h5F);
    check("R7 not yet", pin_level, 8'hFF);
    cyc();
    check("R7 pulled low", pin_level, 8'h5F);
    check("R9 chg pulse", pin_chg, 8'hA0);
    stop_evt();
    check("R9 chg single cycle", pin_chg, 8'h00);
  endtask

  task automatic t_no_autoinc();
    start_evt(); send(8'h01); send(8'hFF); send(8'h3C); stop_evt();
    cyc();
    check("R3 level after two writes", pin_level, 8'h3F);
    read_reg("R3 output holds last", 8'h01, 8'h3C);
    read_reg("R3 polarity untouched", 8'h02, 8'h00);
    read_reg("R3 config untouched", 8'h03, 8'h0F);
  endtask

  task automatic t_rearm();
    start_evt(); send(8'h02); stop_evt();
    start_evt(); send(8'hAA); send(8'h55); stop_evt();
    read_cur("R4 R2 byte after event is pointer", 8'h55);
    check("R10 level unchanged", pin_level, 8'h3F);
    check("R10 no chg", pin_chg, 8'h00);
    read_reg("R5 input xor polarity", 8'h00, 8'h6A);
    bus_start = 1'b1; wr_valid = 1'b1; wr_byte = 8'h03; cyc();
    bus_start = 1'b0; wr_valid = 1'b0;
    send(8'h00);
    read_cur("R4 byte with event dropped", 8'h6A);
    stop_evt();
    check("R4 level unchanged", pin_level, 8'h3F);
  endtask

  task automatic t_input_ro();
    start_evt(); send(8'h00); send(8'h00); cyc();
    check("R6 level unchanged", pin_level, 8'h3F);
    check("R6 no chg", pin_chg, 8'h00);
    start_evt(); read_cur("R6 readback unchanged", 8'h6A); stop_evt();
    start_evt(); send(8'h02); send(8'h00); stop_evt();
  endtask

  task automatic t_ext();
    pin_ext = 8'hFE;
    cyc(); check("R8 edge1", pin_level, 8'h3F);
    cyc(); check("R8 edge2", pin_level, 8'h3F);
    cyc(); check("R8 edge3", pin_level, 8'h3E);
    check("R9 ext chg", pin_chg, 8'h01);
    cyc(); check("R9 ext chg gone", pin_chg, 8'h00);
    pin_ext = 8'h7E;
    for (int k = 0; k < 4; k++) begin
      cyc();
      check("R8 driven pin ignores ext", pin_level, 8'h3E);
      check("R9 no chg driven pin", pin_chg, 8'h00);
    end
    pin_ext = 8'hFF;
    repeat (3) cyc();
    check("R8 restore", pin_level, 8'h3F);
    check("R9 restore chg", pin_chg, 8'h01);
    start_evt(); send(8'h07); send(8'hFF); cyc();
    check("R2 R7 release via config", pin_level, 8'hFF);
    check("R9 release chg", pin_chg, 8'hC0);
    stop_evt();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_drive_low();
    t_no_autoinc();
    t_rearm();
    t_input_ro();
    t_ext();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule